// File: doc/BRIEF.md
# Programmable FIFO Entry Chunk Unpacker

This block takes 32-bit entries from a transmit FIFO and cuts each one into chunks of up to eight bits, ready for a serial shifter. Four 10-bit steering vectors control how it cuts. Each vector names a start bit, a walking direction, a chunk length and a stop flag. The unpacker walks the vectors in order. After the vector that carries the stop flag, it releases the entry and starts again at vector 0 on the next entry. Each chunk carries a flag that marks the final chunk of a protocol word.

The vectors can be set in two ways. The first writes the two 20-bit configuration words verbatim, together with a four-bit word-end mask. The second gives a word size, a count of words per entry and a bit order, and the block derives the vectors itself. It also derives a granularity code for the protocol side. It refuses any combination that would need no vectors or more than four. Chunks leave on a valid/ready port. A chunk appears while an entry is offered, so the block holds no data of its own.

Top module: `fifo_chunk_unpacker`

## Requirements
- R1: A vector is laid out as start index in bits 9:5, direction in bit 4 (1 = walk downward), length minus one in bits 3:1 and stop in bit 0. Vector 0 sits in bits 9:0 of configuration word 0 and vector 1 in bits 19:10. Vectors 2 and 3 sit in the same positions of word 1.
- R2: A derived write uses n = ceil(bpw/8) × words vectors. If n is 0 or greater than 4, the write is refused. A refused write sets `cfg_rejected`, and the words, the granularity and the word-end mask all keep their previous values. An accepted write clears `cfg_rejected`.
- R3: For a derived write, write nb = ceil(bpw/8). Vector i serves word w = i / nb, chunk j = i mod nb. Its start is 8·nb·w + bpw − 1 − 8j when MSB-first and 8·nb·w + 8j when LSB-first. Its direction bit equals the MSB-first setting.
- R4: For a derived write, the length field is min(bpw − 8j, 8) − 1. The stop bit is set only on vector n − 1, and vectors at n and above are all zero.
- R5: An accepted derived write sets `cfg_gran` to bpw/16, which gives 0 for four 8-bit words, 1 for two 16-bit words and 2 for one 32-bit word. A raw write leaves `cfg_gran` unchanged.
- R6: A raw write (`cfg_mode` = 0) stores `cfg_raw0`, `cfg_raw1` and `cfg_raw_wend` verbatim and clears `cfg_rejected`.
- R7: Chunk bit k, for k ≤ length, is entry bit start + k when direction is 0 and entry bit start − k when direction is 1. An index outside 0..31 gives 0, and chunk bits above the length are 0.
- R8: `out_last` is high with a valid chunk when the word-end bit of the current vector is set. In derived mode that bit is set where 8 or fewer bits of the word were left.
- R9: `in_ready` is high only while a chunk is being accepted from the vector with the stop flag set, or from vector 3 if no earlier vector stops. The next entry starts at vector 0.
- R10: While `out_ready` is low, `in_ready` stays low and the same chunk stays on the output.
- R11: `out_valid` equals `in_valid`.
- R12: Any configuration write returns the vector pointer to vector 0.
- R13: After reset both words, the mask, `cfg_gran` and `cfg_rejected` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | 0 = raw load, 1 = derive from parameters |
| cfg_raw0 | input | 20 | Raw configuration word 0 (vectors 0,1) |
| cfg_raw1 | input | 20 | Raw configuration word 1 (vectors 2,3) |
| cfg_raw_wend | input | 4 | Raw word-end mask, bit i for vector i |
| cfg_bpw | input | 6 | Bits per protocol word |
| cfg_words | input | 3 | Protocol words per entry |
| cfg_msb_first | input | 1 | Bit order for derived vectors |
| cfg_word0 | output | 20 | Active configuration word 0 |
| cfg_word1 | output | 20 | Active configuration word 1 |
| cfg_gran | output | 2 | Granularity code |
| cfg_rejected | output | 1 | Last derived write was refused |
| in_valid | input | 1 | FIFO entry offered |
| in_ready | output | 1 | FIFO entry consumed |
| in_data | input | 32 | FIFO entry |
| out_valid | output | 1 | Chunk valid |
| out_ready | input | 1 | Chunk accepted |
| out_data | output | 8 | Chunk, zero-extended |
| out_last | output | 1 | Final chunk of a protocol word |

## Verification
The bench builds the block with its default 32-bit entry, 8-bit chunk and four vectors. At that size it can sweep every word size from 0 to 40, every word count from 0 to 7 and both bit orders. That sweep covers each refused and accepted derivation, and for each accepted one it streams an entry through the slicer. Raw vector sets reach the cases a derivation never makes: indices that fall off either end of the entry, a missing stop flag, and an arbitrary word-end mask. Separate sequences hold `out_ready` low and write the configuration in the middle of an entry.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
    localparam int ENTRY_W      = 32;
    localparam int CHUNK_W      = 8;
    localparam int NUM_VEC      = 4;
    localparam int VEC_PER_WORD = 2;
    localparam int IDX_W        = $clog2(ENTRY_W);
    localparam int LEN_W        = $clog2(CHUNK_W);
    localparam int VEC_W        = IDX_W + 1 + LEN_W + 1;
    localparam int CFG_W        = VEC_W * VEC_PER_WORD;
    localparam int BPW_W        = IDX_W + 1;
    localparam int WORDS_W      = 3;
    localparam int PTR_W        = $clog2(NUM_VEC);
    localparam int GRAN_W       = 2;
    localparam int GRAN_DIV     = 16;

    typedef struct packed {
        logic [IDX_W-1:0] start;
        logic             msb_dir;
        logic [LEN_W-1:0] len_m1;
        logic             stop;
    } pack_vec_t;

    typedef logic [NUM_VEC-1:0][VEC_W-1:0] vec_set_t;

    typedef struct packed {
        logic               ok;
        vec_set_t           vecs;
        logic [NUM_VEC-1:0] wend;
        logic [GRAN_W-1:0]  gran;
    } cfg_calc_t;

    typedef enum logic {
        CFG_RAW  = 1'b0,
        CFG_CALC = 1'b1
    } cfg_mode_e;

    // Walk the word size across the vectors the way a serial word is split.
    function automatic cfg_calc_t calc_vectors(input logic [BPW_W-1:0]   bpw,
                                               input logic [WORDS_W-1:0] words,
                                               input logic               msb);
        cfg_calc_t r;
        int nb, iters, idx, idx0, delta, left, len;
        r     = '0;
        nb    = (int'(bpw) + CHUNK_W - 1) / CHUNK_W;
        iters = nb * int'(words);
        if (iters == 0 || iters > NUM_VEC) begin
            r.ok = 1'b0;
            return r;
        end
        r.ok  = 1'b1;
        idx0  = msb ? int'(bpw) - 1 : 0;
        idx   = idx0;
        left  = int'(bpw);
        delta = msb ? -CHUNK_W : CHUNK_W;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (i < iters) begin
                len = ((left < CHUNK_W) ? left : CHUNK_W) - 1;
                r.vecs[i] = {IDX_W'(idx), msb, LEN_W'(len), 1'b0};
                if (left <= CHUNK_W) begin
                    r.wend[i] = 1'b1;
                    idx  = (i + 1) * CHUNK_W + idx0;
                    left = int'(bpw);
                end else begin
                    idx  = idx + delta;
                    left = left - CHUNK_W;
                end
            end
        end
        r.vecs[iters-1][0] = 1'b1;
        r.gran = GRAN_W'(int'(bpw) / GRAN_DIV);
        return r;
    endfunction

    function automatic pack_vec_t pick_vec(input vec_set_t vecs,
                                           input logic [PTR_W-1:0] p);
        return pack_vec_t'(vecs[p]);
    endfunction
endpackage

// File: rtl/unpk_cfg_regs.sv
module unpk_cfg_regs
    import unpk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  cfg_mode_e           mode,
    input  logic [CFG_W-1:0]    raw0,
    input  logic [CFG_W-1:0]    raw1,
    input  logic [NUM_VEC-1:0]  raw_wend,
    input  logic [BPW_W-1:0]    bpw,
    input  logic [WORDS_W-1:0]  words,
    input  logic                msb_first,
    output vec_set_t            vecs,
    output logic [NUM_VEC-1:0]  wend,
    output logic [GRAN_W-1:0]   gran,
    output logic                rejected
);
    cfg_calc_t calc;

    always_comb calc = calc_vectors(bpw, words, msb_first);

    always_ff @(posedge clk) begin
        if (rst) begin
            vecs     <= '0;
            wend     <= '0;
            gran     <= '0;
            rejected <= 1'b0;
        end else if (cfg_wr) begin
            if (mode == CFG_RAW) begin
                vecs     <= vec_set_t'({raw1, raw0});
                wend     <= raw_wend;
                rejected <= 1'b0;
            end else if (calc.ok) begin
                vecs     <= calc.vecs;
                wend     <= calc.wend;
                gran     <= calc.gran;
                rejected <= 1'b0;
            end else begin
                rejected <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/unpk_slicer.sv
module unpk_slicer
    import unpk_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  pack_vec_t          vec,
    output logic [CHUNK_W-1:0] chunk
);
    always_comb begin
        int pos;
        chunk = '0;
        for (int k = 0; k < CHUNK_W; k++) begin
            pos = vec.msb_dir ? int'(vec.start) - k : int'(vec.start) + k;
            if (k <= int'(vec.len_m1) && pos >= 0 && pos < ENTRY_W)
                chunk[k] = entry[pos];
        end
    end
endmodule

// File: rtl/unpk_seq.sv
module unpk_seq
    import unpk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic             cur_stop,
    output logic [PTR_W-1:0] ptr,
    output logic             pop
);
    logic last_vec;
    logic take;

    assign last_vec = cur_stop || (ptr == PTR_W'(NUM_VEC - 1));
    assign take     = in_valid && out_ready;
    assign pop      = take && last_vec;

    always_ff @(posedge clk) begin
        if (rst || cfg_wr)
            ptr <= '0;
        else if (take)
            ptr <= last_vec ? '0 : ptr + PTR_W'(1);
    end
endmodule

// File: rtl/fifo_chunk_unpacker.sv
module fifo_chunk_unpacker
    import unpk_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic                     cfg_mode,
    input  logic [CFG_W-1:0]         cfg_raw0,
    input  logic [CFG_W-1:0]         cfg_raw1,
    input  logic [NUM_VEC-1:0]       cfg_raw_wend,
    input  logic [BPW_W-1:0]         cfg_bpw,
    input  logic [WORDS_W-1:0]       cfg_words,
    input  logic                     cfg_msb_first,
    output logic [CFG_W-1:0]         cfg_word0,
    output logic [CFG_W-1:0]         cfg_word1,
    output logic [GRAN_W-1:0]        cfg_gran,
    output logic                     cfg_rejected,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ENTRY_W-1:0]       in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [CHUNK_W-1:0]       out_data,
    output logic                     out_last
);
    vec_set_t           vecs;
    logic [NUM_VEC-1:0] wend;
    logic [PTR_W-1:0]   ptr_q;
    pack_vec_t          cur_vec;

    unpk_cfg_regs cfg_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .mode     (cfg_mode_e'(cfg_mode)),
        .raw0     (cfg_raw0),
        .raw1     (cfg_raw1),
        .raw_wend (cfg_raw_wend),
        .bpw      (cfg_bpw),
        .words    (cfg_words),
        .msb_first(cfg_msb_first),
        .vecs     (vecs),
        .wend     (wend),
        .gran     (cfg_gran),
        .rejected (cfg_rejected)
    );

    assign cur_vec = pick_vec(vecs, ptr_q);

    unpk_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .cur_stop (cur_vec.stop),
        .ptr      (ptr_q),
        .pop      (in_ready)
    );

    unpk_slicer slice_i (
        .entry(in_data),
        .vec  (cur_vec),
        .chunk(out_data)
    );

    assign {cfg_word1, cfg_word0} = vecs;
    assign out_valid = in_valid;
    assign out_last  = in_valid && wend[ptr_q];
endmodule

// File: rtl/unpk_checker.sv
module unpk_checker
    import unpk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_wr,
    input logic               cfg_mode,
    input logic [CFG_W-1:0]   cfg_word0,
    input logic [CFG_W-1:0]   cfg_word1,
    input logic [GRAN_W-1:0]  cfg_gran,
    input logic               cfg_rejected,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_last,
    input logic [PTR_W-1:0]   vec_ptr
);
    a_r2_refusal_keeps: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && cfg_mode |=> (!cfg_rejected ||
            ($stable(cfg_word0) && $stable(cfg_word1) && $stable(cfg_gran))));

    a_r6_raw_clears_flag: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && !cfg_mode |=> !cfg_rejected);

    a_r9_pop_with_accept: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> out_valid && out_ready);

    a_r9_pop_restarts: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> vec_ptr == '0);

    a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !cfg_wr |=> vec_ptr == $past(vec_ptr));

    a_r10_no_pop_in_stall: assert property (@(posedge clk) disable iff (rst)
        !out_ready |-> !in_ready);

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid == in_valid);

    a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    a_r12_cfg_restart: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> vec_ptr == '0);
endmodule

bind fifo_chunk_unpacker unpk_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_mode    (cfg_mode),
    .cfg_word0   (cfg_word0),
    .cfg_word1   (cfg_word1),
    .cfg_gran    (cfg_gran),
    .cfg_rejected(cfg_rejected),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_last    (out_last),
    .vec_ptr     (ptr_q)
);

// File: tb/fifo_chunk_unpacker_tb_top.sv
module fifo_chunk_unpacker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_mode = 1'b0;
    logic [19:0] cfg_raw0 = '0, cfg_raw1 = '0;
    logic [3:0]  cfg_raw_wend = '0;
    logic [5:0]  cfg_bpw = '0;
    logic [2:0]  cfg_words = '0;
    logic        cfg_msb_first = 1'b0;
    logic [19:0] cfg_word0, cfg_word1;
    logic [1:0]  cfg_gran;
    logic        cfg_rejected;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fifo_chunk_unpacker dut_i (.*);

    task automatic chk(input bit good, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_cmp++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chkv(input string tag, input logic [39:0] act, input logic [39:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // Closed-form expectation of a derived configuration (R2..R5, R8).
    function automatic void exp_cfg(input int bpw, input int words, input int msb,
                                    output bit ok, output logic [39:0] v,
                                    output logic [3:0] we, output logic [1:0] gr);
        int nb, n, w, j, len, st;
        logic [9:0] one;
        nb = (bpw + 7) / 8;
        n  = nb * words;
        v = '0; we = '0; gr = 2'(bpw / 16);
        ok = (n != 0) && (n <= 4);
        if (!ok) return;
        for (int i = 0; i < n; i++) begin
            w = i / nb; j = i % nb;
            len = ((bpw - 8*j) < 8 ? (bpw - 8*j) : 8) - 1;
            st  = msb ? (8*nb*w + bpw - 1 - 8*j) : (8*nb*w + 8*j);
            one = {5'(st), 1'(msb), 3'(len), (i == n-1)};
            v[i*10 +: 10] = one;
            we[i] = (j == nb - 1);
        end
    endfunction

    function automatic logic [7:0] word_chunk(input logic [31:0] d, input int bpw,
                                              input int msb, input int base, input int j);
        logic [7:0] c = '0;
        int rem = bpw - 8*j;
        for (int k = 0; k < 8; k++)
            if (k < rem)
                c[k] = msb ? d[base + bpw - 1 - 8*j - k] : d[base + 8*j + k];
        return c;
    endfunction

    task automatic write_calc(input int bpw, input int words, input int msb);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = 1'b1;
        cfg_bpw = 6'(bpw); cfg_words = 3'(words); cfg_msb_first = 1'(msb);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic write_raw(input logic [19:0] w0, input logic [19:0] w1, input logic [3:0] we);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = 1'b0;
        cfg_raw0 = w0; cfg_raw1 = w1; cfg_raw_wend = we;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Stream one entry through a derived configuration, checking every chunk (R7..R9, R11).
    task automatic stream_calc(input logic [31:0] d, input int bpw, input int words, input int msb);
        int nb = (bpw + 7) / 8;
        int n  = nb * words;
        in_valid = 1'b1; in_data = d; out_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            chkv("R7 chunk data", 40'(out_data), 40'(word_chunk(d, bpw, msb, 8*nb*(i/nb), i%nb)));
            chkv("R8 word end", 40'(out_last), 40'((i % nb) == nb - 1));
            chkv("R9 entry pop", 40'(in_ready), 40'(i == n - 1));
            chkv("R11 valid", 40'(out_valid), 40'd1);
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0;
    endtask

    function automatic logic [9:0] mkvec(input int st, input int dir, input int len, input int stop);
        return {5'(st), 1'(dir), 3'(len), 1'(stop)};
    endfunction

    function automatic logic [7:0] raw_ref(input logic [31:0] d, input int st, input int dir, input int len);
        logic [7:0] c = '0;
        int p;
        for (int k = 0; k <= len; k++) begin
            p = dir ? st - k : st + k;
            if (p >= 0 && p < 32) c[k] = d[p];
        end
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [39:0] ev, prev_v;
        logic [3:0]  ew;
        logic [1:0]  eg, prev_g;
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chkv("R13 word0 reset", 40'(cfg_word0), 40'd0);
        chkv("R13 word1 reset", 40'(cfg_word1), 40'd0);
        chkv("R13 gran reset", 40'(cfg_gran), 40'd0);
        chkv("R13 rejected reset", 40'(cfg_rejected), 40'd0);
        chkv("R11 idle valid", 40'(out_valid), 40'd0);
        chkv("R9 idle ready", 40'(in_ready), 40'd0);

        // Sweep of derived configurations: R1..R5, R7, R8, R9
        prev_v = '0; prev_g = '0;
        for (int bpw = 0; bpw <= 40; bpw++) begin
            for (int words = 0; words < 8; words++) begin
                for (int msb = 0; msb < 2; msb++) begin
                    exp_cfg(bpw, words, msb, ok, ev, ew, eg);
                    write_calc(bpw, words, msb);
                    chkv("R2 reject flag", 40'(cfg_rejected), 40'(!ok));
                    if (ok) begin
                        chkv("R1 R3 R4 word0", 40'(cfg_word0), 40'(ev[19:0]));
                        chkv("R1 R3 R4 word1", 40'(cfg_word1), 40'(ev[39:20]));
                        chkv("R5 gran", 40'(cfg_gran), 40'(eg));
                        prev_v = ev; prev_g = eg;
                        d = 32'h9E37_79B9 ^ (32'(bpw) * 32'h0101_0101) ^ (32'(words) << (msb ? 7 : 19));
                        stream_calc(d, bpw, words, msb);
                    end else begin
                        chkv("R2 kept words", {cfg_word1, cfg_word0}, prev_v);
                        chkv("R2 kept gran", 40'(cfg_gran), 40'(prev_g));
                    end
                end
            end
        end

        // R6, R7: raw vectors with out-of-range indices and a stop on vector 2
        write_raw({mkvec(4, 0, 7, 0), mkvec(31, 1, 7, 0)},
                  {mkvec(9, 0, 3, 1), mkvec(2, 1, 5, 1)}, 4'b0110);
        chkv("R6 raw word0", 40'(cfg_word0), 40'({mkvec(4, 0, 7, 0), mkvec(31, 1, 7, 0)}));
        chkv("R6 raw word1", 40'(cfg_word1), 40'({mkvec(9, 0, 3, 1), mkvec(2, 1, 5, 1)}));
        chkv("R6 raw rejected", 40'(cfg_rejected), 40'd0);
        chkv("R5 raw keeps gran", 40'(cfg_gran), 40'(prev_g));
        d = 32'hC3A5_5A3C;
        in_valid = 1'b1; in_data = d; out_ready = 1'b1;
        #1;
        chkv("R7 raw v0", 40'(out_data), 40'(raw_ref(d, 31, 1, 7)));
        chkv("R8 raw v0 last", 40'(out_last), 40'd0);
        chkv("R9 raw v0 ready", 40'(in_ready), 40'd0);
        @(negedge clk); #1;
        chkv("R7 raw v1", 40'(out_data), 40'(raw_ref(d, 4, 0, 7)));
        chkv("R8 raw v1 last", 40'(out_last), 40'd1);
        @(negedge clk); #1;
        chkv("R7 raw v2 low edge", 40'(out_data), 40'(raw_ref(d, 2, 1, 5)));
        chkv("R9 raw stop pop", 40'(in_ready), 40'd1);
        @(negedge clk); #1;
        chkv("R9 raw restart v0", 40'(out_data), 40'(raw_ref(d, 31, 1, 7)));
        in_valid = 1'b0; out_ready = 1'b0;

        // R9: no stop anywhere, entry released after vector 3 (start 30 runs off the top)
        write_raw({mkvec(8, 0, 7, 0), mkvec(0, 0, 7, 0)},
                  {mkvec(30, 0, 7, 0), mkvec(16, 0, 7, 0)}, 4'b0000);
        d = 32'h1234_ABCD;
        in_valid = 1'b1; in_data = d; out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1;
            chkv("R7 nostop chunk", 40'(out_data), 40'(raw_ref(d, (i == 3) ? 30 : 8*i, 0, 7)));
            chkv("R9 nostop pop", 40'(in_ready), 40'(i == 3));
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0;

        // R10 stall and R12 restart on configuration write
        write_calc(8, 4, 0);
        d = 32'hF00D_BEEF;
        in_valid = 1'b1; in_data = d; out_ready = 1'b0;
        for (int c = 0; c < 3; c++) begin
            #1;
            chkv("R10 stall data", 40'(out_data), 40'(d[7:0]));
            chkv("R10 stall ready", 40'(in_ready), 40'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1; chkv("R10 resume v0", 40'(out_data), 40'(d[7:0]));
        @(negedge clk); #1; chkv("R10 resume v1", 40'(out_data), 40'(d[15:8]));
        @(negedge clk);
        out_ready = 1'b0;
        cfg_wr = 1'b1; cfg_mode = 1'b1; cfg_bpw = 6'd8; cfg_words = 3'd4; cfg_msb_first = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1; chkv("R12 restart at vector 0", 40'(out_data), 40'(d[7:0]));
        in_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule